// File: doc/BRIEF.md
# Program Trace Stream Compressor

This block sits beside a processor core and watches its trace outputs: a 5-bit status word sampled every clock, plus a strobe and a 30-bit address for each show cycle. The core may report instructions and later revoke them. The compressor holds each reported instruction in a short pending window until no later flush can reach it. Revoked instructions leave no trace. Instructions that survive are turned into a compact record stream.

Straight-line instructions only increment a counter. Conditional branches produce a record that gives the outcome and carries the count of straight-line instructions before the branch. Indirect flow changes produce a record that carries the target address, preceded by a count record when the count is nonzero. Records leave on a valid/ready interface. The output has one output register and one skid register. A sticky flag reports any record that had to be discarded.

Top module: `trc_compress`

## Requirements
- R1: Status bits [2:0] give the instruction kind: 1 is sequential, 2 is branch taken, 3 is branch not taken, 4 is indirect flow change. Codes 0, 5, 6 and 7 report no instruction and have no effect.
- R2: Status bits [4:3] give a flush count N. N cancels the N newest pending instructions, or all of them if fewer are pending. The flush acts before any instruction reported in the same cycle. A cancelled instruction never shows up in the output.
- R3: A pending instruction commits only in the cycle when the third later instruction is reported after it. At most three instructions stay pending between cycles. Idle cycles commit nothing.
- R4: A committed sequential instruction adds one to a 16-bit count and emits no record.
- R5: A committed branch emits one record and clears the count. The record kind is 1 for taken and 2 for not taken. The payload is the count before the branch, zero-extended.
- R6: A committed indirect flow change clears the count. If the count was nonzero, it first emits a kind 0 record with the count. It then emits a kind 3 record with the target address. The target is the show address captured in the cycle of the report when the show strobe is high. Otherwise it is the address of the most recent earlier show cycle, or 0 if none has occurred since reset.
- R7: When a sequential commit would bring the count to 65535, the block emits a kind 0 record with payload 65535, and the count restarts at 0.
- R8: A record appears on the output the clock edge after the cycle in which the committing instruction was reported. The record stays valid and unchanged until a cycle with ready high. Records leave in the order they were formed.
- R9: The output holds at most two records (the output register plus one skid record). A record arriving when both are occupied is discarded, and the drop flag sets and stays set.
- R10: A synchronous active-high reset empties the pending window, the output and the skid register. It clears the count, the drop flag and the last show address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_stat_i | input | 5 | Per-clock status: kind in [2:0], flush count in [4:3] |
| show_stb_i | input | 1 | Show cycle strobe |
| show_addr_i | input | 30 | Show cycle address |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Consumer accepts the record this cycle |
| rec_kind_o | output | 2 | Record kind: 0 count, 1 taken, 2 not taken, 3 indirect |
| rec_data_o | output | 30 | Record payload: count or target address |
| rec_drop_o | output | 1 | Sticky flag: a record was discarded |

## Verification
A wrong count or a stale pending entry shows up at the next committed flow change: a branch payload differs, or an extra or missing kind 0 record appears. A mis-cancelled instruction shifts the whole later record sequence. The bench compares the output every cycle against a model of the window, the counter and the two-slot output, so any divergence is reported in the cycle it reaches the port. A corrupted output stage shows up at once as a changed record under backpressure or as a wrong drop flag.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Instruction queue status codes in the low status bits
  localparam logic [2:0] QC_SEQ    = 3'd1;
  localparam logic [2:0] QC_TAKEN  = 3'd2;
  localparam logic [2:0] QC_NTAKEN = 3'd3;
  localparam logic [2:0] QC_IND    = 3'd4;

  typedef enum logic [1:0] {
    IK_SEQ    = 2'd0,
    IK_TAKEN  = 2'd1,
    IK_NTAKEN = 2'd2,
    IK_IND    = 2'd3
  } ikind_e;

  typedef enum logic [1:0] {
    RK_COUNT  = 2'd0,
    RK_TAKEN  = 2'd1,
    RK_NTAKEN = 2'd2,
    RK_IND    = 2'd3
  } rkind_e;

  localparam int RK_W = 2;
endpackage

// File: rtl/trc_pending.sv
module trc_pending
  import trc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int FL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  ikind_e            kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FL_W-1:0]   flush_i,
  output logic              commit_o,
  output ikind_e            ckind_o,
  output logic [ADDR_W-1:0] caddr_o
);
  localparam int HOLD = (1 << FL_W) - 1;

  logic [FL_W-1:0]   cnt_q;
  logic [FL_W-1:0]   kept;
  ikind_e            kind_q [HOLD];
  logic [ADDR_W-1:0] addr_q [HOLD];

  // flush removes the newest entries before the new report is placed
  always_comb kept = (cnt_q > flush_i) ? cnt_q - flush_i : '0;

  assign commit_o = push_i && (kept == FL_W'(HOLD));
  assign ckind_o  = kind_q[0];
  assign caddr_o  = addr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (commit_o) begin
      for (int i = 0; i < HOLD - 1; i++) begin
        kind_q[i] <= kind_q[i+1];
        addr_q[i] <= addr_q[i+1];
      end
      kind_q[HOLD-1] <= kind_i;
      addr_q[HOLD-1] <= addr_i;
    end else if (push_i) begin
      for (int i = 0; i < HOLD; i++) begin
        if (kept == FL_W'(i)) begin
          kind_q[i] <= kind_i;
          addr_q[i] <= addr_i;
        end
      end
      cnt_q <= kept + 1'b1;
    end else begin
      cnt_q <= kept;
    end
  end

  // R3: after a commit the window is still full
  assert_full_after_commit_R3: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (cnt_q == FL_W'(HOLD)));
endmodule

// File: rtl/trc_seqcnt.sv
module trc_seqcnt
  import trc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  ikind_e            kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        rec_n_o,
  output logic [RK_W+ADDR_W-1:0] rec0_o,
  output logic [RK_W+ADDR_W-1:0] rec1_o
);
  localparam int PAD_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [ADDR_W-1:0] cnt_pay;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_pay = {{PAD_W{1'b0}}, cnt_q};

  always_comb begin
    cnt_d   = cnt_q;
    rec_n_o = 2'd0;
    rec0_o  = '0;
    rec1_o  = '0;
    if (commit_i) begin
      case (kind_i)
        IK_SEQ: begin
          if (&cnt_inc) begin
            rec_n_o = 2'd1;
            rec0_o  = {RK_COUNT, {PAD_W{1'b0}}, cnt_inc};
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        IK_TAKEN: begin
          rec_n_o = 2'd1;
          rec0_o  = {RK_TAKEN, cnt_pay};
          cnt_d   = '0;
        end
        IK_NTAKEN: begin
          rec_n_o = 2'd1;
          rec0_o  = {RK_NTAKEN, cnt_pay};
          cnt_d   = '0;
        end
        default: begin
          if (cnt_q != '0) begin
            rec_n_o = 2'd2;
            rec0_o  = {RK_COUNT, cnt_pay};
            rec1_o  = {RK_IND, addr_i};
          end else begin
            rec_n_o = 2'd1;
            rec0_o  = {RK_IND, addr_i};
          end
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R7: the count is emitted before it can reach all ones
  assert_cnt_below_max_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q != {CNT_W{1'b1}});
  // R5: a committed branch leaves the count at zero
  assert_flow_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (commit_i && kind_i != IK_SEQ) |=> (cnt_q == '0));
endmodule

// File: rtl/trc_outq.sv
module trc_outq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   in_n_i,
  input  logic [W-1:0] in0_i,
  input  logic [W-1:0] in1_i,
  input  logic         rdy_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o,
  output logic         drop_o
);
  localparam int SLOTS = 4;

  logic         o_v, s_v;
  logic [W-1:0] o_d, s_d;
  logic [W-1:0] a [SLOTS];
  logic [2:0]   num;

  // gather what remains after this cycle's pop, oldest first
  always_comb begin
    for (int i = 0; i < SLOTS; i++) a[i] = '0;
    num = '0;
    if (o_v && !rdy_i) begin
      a[num[1:0]] = o_d;
      num = num + 1'b1;
    end
    if (s_v) begin
      a[num[1:0]] = s_d;
      num = num + 1'b1;
    end
    if (in_n_i != 2'd0) begin
      a[num[1:0]] = in0_i;
      num = num + 1'b1;
    end
    if (in_n_i == 2'd2) begin
      a[num[1:0]] = in1_i;
      num = num + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_v    <= 1'b0;
      s_v    <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      o_v <= (num >= 3'd1);
      s_v <= (num >= 3'd2);
      if (num > 3'd2) drop_o <= 1'b1;
    end
    o_d <= a[0];
    s_d <= a[1];
  end

  assign vld_o = o_v;
  assign dat_o = o_d;

  // R8: a stalled record is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (o_v && !rdy_i) |=> (o_v && $stable(o_d)));
  // R9: the drop flag is sticky
  assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> drop_o);
  // R9: the skid slot only fills behind an occupied output register
  assert_skid_order_R9: assert property (@(posedge clk) disable iff (rst)
    s_v |-> o_v);
endmodule

// File: rtl/trc_compress.sv
module trc_compress
  import trc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int STAT_W = 5,
  parameter int FL_W   = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] trc_stat_i,
  input  logic              show_stb_i,
  input  logic [ADDR_W-1:0] show_addr_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [1:0]        rec_kind_o,
  output logic [ADDR_W-1:0] rec_data_o,
  output logic              rec_drop_o
);
  localparam int Q_W   = STAT_W - FL_W;
  localparam int REC_W = RK_W + ADDR_W;

  logic [Q_W-1:0]    qcode;
  logic [FL_W-1:0]   flush;
  logic              push;
  ikind_e            pkind;
  logic [ADDR_W-1:0] paddr, last_addr;
  logic              commit;
  ikind_e            ckind;
  logic [ADDR_W-1:0] caddr;
  logic [1:0]        rec_n;
  logic [REC_W-1:0]  rec0, rec1, out_d;

  assign qcode = trc_stat_i[Q_W-1:0];
  assign flush = trc_stat_i[STAT_W-1:Q_W];
  assign paddr = show_stb_i ? show_addr_i : last_addr;

  always_comb begin
    push  = 1'b1;
    pkind = IK_SEQ;
    case (qcode)
      Q_W'(QC_SEQ):    pkind = IK_SEQ;
      Q_W'(QC_TAKEN):  pkind = IK_TAKEN;
      Q_W'(QC_NTAKEN): pkind = IK_NTAKEN;
      Q_W'(QC_IND):    pkind = IK_IND;
      default:         push  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             last_addr <= '0;
    else if (show_stb_i) last_addr <= show_addr_i;
  end

  trc_pending #(.ADDR_W(ADDR_W), .FL_W(FL_W)) i_pend (
    .clk(clk), .rst(rst), .push_i(push), .kind_i(pkind), .addr_i(paddr),
    .flush_i(flush), .commit_o(commit), .ckind_o(ckind), .caddr_o(caddr)
  );

  trc_seqcnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .commit_i(commit), .kind_i(ckind), .addr_i(caddr),
    .rec_n_o(rec_n), .rec0_o(rec0), .rec1_o(rec1)
  );

  trc_outq #(.W(REC_W)) i_outq (
    .clk(clk), .rst(rst), .in_n_i(rec_n), .in0_i(rec0), .in1_i(rec1),
    .rdy_i(rec_ready_i), .vld_o(rec_valid_o), .dat_o(out_d), .drop_o(rec_drop_o)
  );

  assign rec_kind_o = out_d[REC_W-1 -: RK_W];
  assign rec_data_o = out_d[ADDR_W-1:0];

  // R6: a show cycle updates the held target address
  assert_last_addr_R6: assert property (@(posedge clk) disable iff (rst)
    show_stb_i |=> (last_addr == $past(show_addr_i)));
endmodule

// File: tb/test_trc_compress.sv
`timescale 1ns/1ps
module test_trc_compress;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  trc_stat_i;
  logic        show_stb_i;
  logic [29:0] show_addr_i;
  logic        rec_valid_o, rec_ready_i, rec_drop_o;
  logic [1:0]  rec_kind_o;
  logic [29:0] rec_data_o;

  always #2 clk = ~clk;

  trc_compress i_trc_compress (
    .clk(clk), .rst(rst), .trc_stat_i(trc_stat_i), .show_stb_i(show_stb_i),
    .show_addr_i(show_addr_i), .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
    .rec_kind_o(rec_kind_o), .rec_data_o(rec_data_o), .rec_drop_o(rec_drop_o)
  );

  typedef struct { int k; logic [29:0] a; } pent_t;
  pent_t       pq[$];
  logic [31:0] oq[$];
  int          mcnt;
  bit          movf;
  logic [29:0] mlast;
  int          vecs = 0, errs = 0, cyc_cnt = 0;
  bit          seen_max = 0;

  function automatic void mrec(logic [1:0] k, logic [29:0] p);
    oq.push_back({k, p});
  endfunction

  function automatic void mcommit(pent_t e);
    case (e.k)
      1: begin
        mcnt++;
        if (mcnt == 65535) begin mrec(2'd0, 30'(mcnt)); mcnt = 0; end
      end
      2: begin mrec(2'd1, 30'(mcnt)); mcnt = 0; end
      3: begin mrec(2'd2, 30'(mcnt)); mcnt = 0; end
      default: begin
        if (mcnt != 0) mrec(2'd0, 30'(mcnt));
        mrec(2'd3, e.a);
        mcnt = 0;
      end
    endcase
  endfunction

  function automatic void mstep(logic [4:0] st, logic sh, logic [29:0] ad, logic rd);
    int fl, code;
    pent_t e;
    if (rd && oq.size() > 0) void'(oq.pop_front());
    fl = int'(st[4:3]);
    code = int'(st[2:0]);
    for (int i = 0; i < fl; i++) if (pq.size() > 0) void'(pq.pop_back());
    if (code >= 1 && code <= 4) begin
      e.k = code;
      e.a = sh ? ad : mlast;
      if (pq.size() == 3) mcommit(pq.pop_front());
      pq.push_back(e);
    end
    if (sh) mlast = ad;
    while (oq.size() > 2) begin void'(oq.pop_back()); movf = 1; end
  endfunction

  function automatic void mclear();
    pq.delete(); oq.delete(); mcnt = 0; movf = 0; mlast = '0;
  endfunction

  task automatic check(string tag);
    bit ev;
    ev = (oq.size() > 0);
    vecs++;
    if (rec_valid_o !== ev || rec_drop_o !== movf ||
        (ev && {rec_kind_o, rec_data_o} !== oq[0])) begin
      errs++;
      $display("FAIL %s: valid=%0b drop=%0b rec=%h, expected valid=%0b drop=%0b rec=%h",
               tag, rec_valid_o, rec_drop_o, {rec_kind_o, rec_data_o},
               ev, movf, ev ? oq[0] : 32'h0);
    end
    if (ev && oq[0] == {2'd0, 30'd65535} && rec_valid_o && rec_data_o == 30'd65535)
      seen_max = 1;
  endtask

  task automatic cyc(logic [4:0] st, logic sh, logic [29:0] ad, logic rd, string tag);
    check(tag);
    trc_stat_i  = st;
    show_stb_i  = sh;
    show_addr_i = ad;
    rec_ready_i = rd;
    mstep(st, sh, ad, rd);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic rd, string tag);
    for (int i = 0; i < n; i++) cyc(5'd0, 1'b0, 30'd0, rd, tag);
  endtask

  task automatic seqs(int n, string tag);
    for (int i = 0; i < n; i++) cyc(5'd1, 1'b0, 30'd0, 1'b1, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; trc_stat_i = '0; show_stb_i = 0; show_addr_i = '0; rec_ready_i = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mclear();
    check("R10");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000) begin
      errs++;
      $display("FAIL watchdog: cycles=%0d, expected below 190000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R4 R5: five sequential then a taken branch, pushed out by three more
    seqs(5, "R4");
    cyc(5'd2, 0, 0, 1, "R5");
    seqs(3, "R5");
    idle(2, 1, "R5");
    cyc(5'd3, 0, 0, 1, "R5");
    seqs(3, "R5");
    idle(2, 1, "R5");

    // R1: unused codes report nothing
    cyc(5'd5, 0, 0, 1, "R1"); cyc(5'd6, 1, 30'h155, 1, "R1"); cyc(5'd7, 0, 0, 1, "R1");
    cyc(5'd2, 0, 0, 1, "R1");
    cyc(5'd0, 0, 0, 1, "R1"); cyc(5'd5, 0, 0, 1, "R1");
    seqs(3, "R1");
    idle(2, 1, "R1");

    // R2: flush cancels newest pending, before a same-cycle report
    cyc(5'd1, 0, 0, 1, "R2");
    cyc(5'd2, 0, 0, 1, "R2");
    cyc({2'd1, 3'd0}, 0, 0, 1, "R2");
    cyc({2'd3, 3'd0}, 0, 0, 1, "R2");
    cyc(5'd2, 0, 0, 1, "R2");
    cyc({2'd1, 3'd3}, 0, 0, 1, "R2");
    seqs(3, "R2");
    idle(2, 1, "R2");

    // R3: a lone report stays pending over idle cycles
    do_reset();
    cyc(5'd2, 0, 0, 1, "R3");
    idle(10, 1, "R3");
    seqs(2, "R3");
    idle(3, 1, "R3");
    seqs(1, "R3");
    idle(2, 1, "R3");

    // R6: indirect targets, with and without a show cycle, with zero count
    seqs(2, "R6");
    cyc(5'd4, 1, 30'h2ABCDEF1, 1, "R6");
    cyc(5'd0, 1, 30'h01234567, 1, "R6");
    cyc(5'd4, 0, 0, 1, "R6");
    cyc(5'd4, 1, 30'h3FFFFFFF, 1, "R6");
    seqs(3, "R6");
    idle(3, 1, "R6");

    // R8: backpressure holds the record, order kept
    cyc(5'd2, 0, 0, 1, "R8");
    cyc(5'd4, 1, 30'h00ABCDE0, 1, "R8");
    seqs(3, "R8");
    idle(6, 0, "R8");
    idle(4, 1, "R8");

    // R9: more records than the two slots while stalled
    for (int i = 0; i < 8; i++) cyc(5'd3, 0, 0, 0, "R9");
    idle(3, 0, "R9");
    idle(4, 1, "R9");

    // R10: reset clears the drop flag and state
    do_reset();
    idle(2, 1, "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] code;
      logic [1:0] fl;
      int r;
      r = $urandom % 16;
      code = (r < 8) ? 3'd1 : (r < 10) ? 3'd2 : (r < 12) ? 3'd3 : (r < 13) ? 3'd4 :
             (r < 14) ? 3'($urandom % 8) : 3'd0;
      fl = ($urandom % 6 == 0) ? 2'($urandom % 4) : 2'd0;
      cyc({fl, code}, ($urandom % 3) == 0, 30'($urandom), ($urandom % 4) != 0, "R2");
    end
    idle(4, 1, "R8");

    // R7: count saturation record
    do_reset();
    seqs(65540, "R7");
    cyc(5'd2, 0, 0, 1, "R7");
    seqs(3, "R7");
    idle(3, 1, "R7");
    vecs++;
    if (!seen_max) begin
      errs++;
      $display("FAIL R7: saturation record seen=%0b, expected 1", seen_max);
    end

    finish_run();
  end
endmodule